// File: doc/BRIEF.md
# ADC output data formatter

This block sits between the sample path of a 12-bit converter and its parallel output pins. On every clock it takes one raw sample in offset binary and its overflow flag. It turns them into a registered 13-bit output word, with the overflow flag in the top bit and the data below it. Static mode inputs pick the format. The format can be plain offset binary, two's complement, a scrambled form in which each upper data bit is XORed with the data LSB, or a form with every odd data bit inverted. The block can also send a fixed or toggling test pattern instead of the data.

The modes stack in a fixed order. When the two's complement conversion is allowed, it is applied first. The scrambler comes next and the odd-bit inversion comes last. The odd-bit inversion forces offset binary, so the two's complement control has no effect while it is on. Any test pattern overrides all formatting and also replaces the overflow bit. A separate disable input clears an output-enable signal. The pad ring uses that signal to put every output pin into high impedance, the overflow pin and the clock output included.

Top module: `adc_out_formatter`

## Requirements
- R1: While reset is asserted, `out_word` is 0 and `out_oe` is 0.
- R2: With every formatting control off and `test_mode` = 0, the `out_word` that follows a clock edge equals {`raw_ovf`, `raw_data`} as sampled at that edge. This is a latency of one clock, and the data stays in offset binary.
- R3: When `twos_comp_en` = 1 and `alt_pol_en` = 0, data bit 11 of the output is the inverse of raw bit 11.
- R4: When `rand_en` = 1, each output data bit 11..1 is XORed with data bit 0, and bit 0 itself is unchanged. This step acts on the word after the two's complement step.
- R5: When `alt_pol_en` = 1, output data bits 1, 3, 5, 7, 9 and 11 are inverted, which is an XOR mask of 0xAAA. This step acts on the word after the scrambler. It works with `rand_en` either on or off.
- R6: When `alt_pol_en` = 1, `twos_comp_en` has no effect and the data stays in offset binary.
- R7: `test_mode` = 1 drives all 13 output bits to 0. `test_mode` = 2 drives all 13 output bits to 1.
- R8: `test_mode` = 3 drives all ones or all zeros depending on a phase bit. The phase bit flips on every clock edge after reset. The first edge after reset produces the all-ones phase.
- R9: `test_mode` = 4 drives 0x1555 (1010101010101, with the overflow bit first) in the first phase and 0x0AAA in the other phase. It uses the same phase bit as R8.
- R10: Test codes 1 to 4 ignore every formatting control and `raw_ovf`. Codes 5, 6 and 7 behave the same as code 0.
- R11: The `out_oe` that follows a clock edge is the inverse of `out_disable` as sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| raw_data | input | 12 | Raw sample in offset binary |
| raw_ovf | input | 1 | Overflow flag of the raw sample |
| twos_comp_en | input | 1 | Select two's complement output |
| rand_en | input | 1 | Enable the LSB-XOR data scrambler |
| alt_pol_en | input | 1 | Invert the odd data bits |
| test_mode | input | 3 | 0 off, 1 zeros, 2 ones, 3 alternating, 4 checkerboard, 5 to 7 off |
| out_disable | input | 1 | Request high impedance on every output, the clock output included |
| out_word | output | 13 | Registered output: overflow in bit 12, data in bits 11..0 |
| out_oe | output | 1 | Output enable for all pads, the clock output included |

## Verification
The assertions run on every cycle. They check the fixed all-zeros and all-ones patterns and the checkerboard values. They also check that the toggling patterns invert from one sample to the next and that the overflow bit passes through when no pattern is selected. Further assertions check two's complement and odd-bit inversion on unscrambled data, and that the output enable follows the disable input. Other behaviour shows up only in the bench scenarios, which compare every output word against an independent model. These include the exact phase that comes first after reset, the order in which the scrambler and the other two steps are applied, the override of formatting by a test pattern, and the handling of the unused test codes as "off".

// File: rtl/adc_out_formatter.sv
module adc_out_formatter #(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] raw_data,
  input  logic              raw_ovf,
  input  logic              twos_comp_en,
  input  logic              rand_en,
  input  logic              alt_pol_en,
  input  logic [2:0]        test_mode,
  input  logic              out_disable,
  output logic [DATA_W:0]   out_word,
  output logic              out_oe
);

  localparam int WORD_W = DATA_W + 1;

  function automatic logic [DATA_W-1:0] odd_bits();
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  function automatic logic [WORD_W-1:0] checker_a();
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = ((WORD_W - 1 - i) % 2) == 0;
    return m;
  endfunction

  localparam logic [DATA_W-1:0] ODD_MASK = odd_bits();
  localparam logic [DATA_W-1:0] MSB_MASK = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [WORD_W-1:0] CHK_A    = checker_a();
  localparam logic [WORD_W-1:0] CHK_B    = ~CHK_A;
  localparam logic [WORD_W-1:0] ONES     = '1;
  localparam logic [WORD_W-1:0] ZEROS    = '0;

  localparam logic [2:0] TM_ZEROS = 3'd1;
  localparam logic [2:0] TM_ONES  = 3'd2;
  localparam logic [2:0] TM_ALT   = 3'd3;
  localparam logic [2:0] TM_CHK   = 3'd4;

  logic              phase_q;
  logic [DATA_W-1:0] tc_d, rnd_d, fmt_d;
  logic [WORD_W-1:0] next_word;

  assign tc_d  = (twos_comp_en && !alt_pol_en) ? (raw_data ^ MSB_MASK) : raw_data;
  assign rnd_d = rand_en ? (tc_d ^ {{(DATA_W-1){tc_d[0]}}, 1'b0}) : tc_d;
  assign fmt_d = alt_pol_en ? (rnd_d ^ ODD_MASK) : rnd_d;

  always_comb begin
    case (test_mode)
      TM_ZEROS: next_word = ZEROS;
      TM_ONES:  next_word = ONES;
      TM_ALT:   next_word = phase_q ? ZEROS : ONES;
      TM_CHK:   next_word = phase_q ? CHK_B : CHK_A;
      default:  next_word = {raw_ovf, fmt_d};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_word <= '0;
      out_oe   <= 1'b0;
      phase_q  <= 1'b0;
    end else begin
      out_word <= next_word;
      out_oe   <= !out_disable;
      phase_q  <= !phase_q;
    end
  end

endmodule

// File: rtl/adc_out_formatter_chk.sv
module adc_out_formatter_chk #(
  parameter int DATA_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic [DATA_W-1:0] raw_data,
  input logic              raw_ovf,
  input logic              twos_comp_en,
  input logic              rand_en,
  input logic              alt_pol_en,
  input logic [2:0]        test_mode,
  input logic              out_disable,
  input logic [DATA_W:0]   out_word,
  input logic              out_oe
);

  localparam int WORD_W = DATA_W + 1;

  function automatic logic [WORD_W-1:0] chk_first();
    logic [WORD_W-1:0] m;
    for (int i = 0; i < WORD_W; i++) m[i] = ((WORD_W - 1 - i) % 2) == 0;
    return m;
  endfunction

  function automatic logic [DATA_W-1:0] odd_sel();
    logic [DATA_W-1:0] m;
    for (int i = 0; i < DATA_W; i++) m[i] = (i % 2) == 1;
    return m;
  endfunction

  localparam logic [WORD_W-1:0] CHK1 = chk_first();
  localparam logic [DATA_W-1:0] ODDS = odd_sel();

  logic warm;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) warm <= 1'b0;
    else        warm <= 1'b1;

  logic fmt_only;
  assign fmt_only = (test_mode == 3'd0) || (test_mode > 3'd4);

  a_r1_reset_state: assert property (@(posedge clk) !rst_n |-> (out_word == '0 && !out_oe));

  a_r7_all_zeros: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode == 3'd1 |=> out_word == '0);

  a_r7_all_ones: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode == 3'd2 |=> out_word == '1);

  a_r8_alt_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && test_mode == 3'd3 && $past(test_mode) == 3'd3) |=> out_word == ~$past(out_word));

  a_r8_alt_values: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode == 3'd3 |=> (out_word == '1 || out_word == '0));

  a_r9_chk_values: assert property (@(posedge clk) disable iff (!rst_n)
    test_mode == 3'd4 |=> (out_word == CHK1 || out_word == ~CHK1));

  a_r9_chk_toggles: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && test_mode == 3'd4 && $past(test_mode) == 3'd4) |=> out_word == ~$past(out_word));

  a_r10_ovf_passes: assert property (@(posedge clk) disable iff (!rst_n)
    fmt_only |=> out_word[DATA_W] == $past(raw_ovf));

  a_r3_twos_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_only && twos_comp_en && !alt_pol_en && !rand_en)
      |=> out_word[DATA_W-1:0] == ($past(raw_data) ^ {1'b1, {(DATA_W-1){1'b0}}}));

  a_r6_alt_forces_offset: assert property (@(posedge clk) disable iff (!rst_n)
    (fmt_only && alt_pol_en && !rand_en)
      |=> out_word[DATA_W-1:0] == ($past(raw_data) ^ ODDS));

  a_r11_oe_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> out_oe == !$past(out_disable));

endmodule

bind adc_out_formatter adc_out_formatter_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .raw_data(raw_data), .raw_ovf(raw_ovf),
  .twos_comp_en(twos_comp_en), .rand_en(rand_en), .alt_pol_en(alt_pol_en),
  .test_mode(test_mode), .out_disable(out_disable),
  .out_word(out_word), .out_oe(out_oe)
);

// File: tb/adc_out_formatter_test.sv
`timescale 1ns/1ps
module adc_out_formatter_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] raw_data = '0;
  logic        raw_ovf = 1'b0;
  logic        twos_comp_en = 1'b0;
  logic        rand_en = 1'b0;
  logic        alt_pol_en = 1'b0;
  logic [2:0]  test_mode = 3'd0;
  logic        out_disable = 1'b0;
  logic [12:0] out_word;
  logic        out_oe;

  int checks = 0;
  int errors = 0;
  int edge_n = 0;
  bit done = 0;

  always #2 clk = ~clk;

  adc_out_formatter uut (
    .clk(clk), .rst_n(rst_n), .raw_data(raw_data), .raw_ovf(raw_ovf),
    .twos_comp_en(twos_comp_en), .rand_en(rand_en), .alt_pol_en(alt_pol_en),
    .test_mode(test_mode), .out_disable(out_disable),
    .out_word(out_word), .out_oe(out_oe)
  );

  function automatic logic [12:0] expect_word(logic [11:0] d, logic ov, logic tc,
                                              logic rn, logic ap, logic [2:0] tm, int n);
    logic [11:0] v;
    case (tm)
      3'd1: return 13'h0000;
      3'd2: return 13'h1FFF;
      3'd3: return (n % 2 == 0) ? 13'h1FFF : 13'h0000;
      3'd4: return (n % 2 == 0) ? 13'h1555 : 13'h0AAA;
      default: begin
        v = d;
        if (tc && !ap) v[11] = ~v[11];
        if (rn) for (int i = 1; i < 12; i++) v[i] = v[i] ^ v[0];
        if (ap) for (int i = 1; i < 12; i += 2) v[i] = ~v[i];
        return {ov, v};
      end
    endcase
  endfunction

  task automatic check(string tag, logic [12:0] got, logic [12:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic step(string tag, logic [11:0] d, logic ov, logic tc, logic rn,
                      logic ap, logic [2:0] tm, logic dis);
    logic [12:0] exp;
    raw_data = d; raw_ovf = ov; twos_comp_en = tc; rand_en = rn;
    alt_pol_en = ap; test_mode = tm; out_disable = dis;
    exp = expect_word(d, ov, tc, rn, ap, tm, edge_n);
    @(posedge clk);
    @(negedge clk);
    edge_n++;
    check(tag, out_word, exp);
    check("R11", {12'd0, out_oe}, {12'd0, !dis});
  endtask

  task automatic burst(string tag, int cnt, logic tc, logic rn, logic ap, logic [2:0] tm);
    for (int k = 0; k < cnt; k++)
      step(tag, 12'($urandom), 1'($urandom), tc, rn, ap, tm, 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", out_word, 13'h0000);
    check("R1", {12'd0, out_oe}, 13'h0000);
    rst_n = 1'b1;

    step("R8", 12'h123, 1'b1, 1'b0, 1'b0, 1'b0, 3'd3, 1'b0);
    step("R8", 12'h456, 1'b0, 1'b1, 1'b1, 1'b1, 3'd3, 1'b0);
    burst("R2", 16, 1'b0, 1'b0, 1'b0, 3'd0);
    step("R2", 12'hFFF, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    step("R2", 12'h000, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    burst("R3", 16, 1'b1, 1'b0, 1'b0, 3'd0);
    step("R3", 12'h800, 1'b0, 1'b1, 1'b0, 1'b0, 3'd0, 1'b0);
    burst("R4", 16, 1'b0, 1'b1, 1'b0, 3'd0);
    step("R4", 12'h001, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
    burst("R4", 12, 1'b1, 1'b1, 1'b0, 3'd0);
    burst("R5", 16, 1'b0, 1'b0, 1'b1, 3'd0);
    burst("R5", 12, 1'b0, 1'b1, 1'b1, 3'd0);
    step("R5", 12'h000, 1'b0, 1'b0, 1'b1, 1'b0, 3'd0, 1'b0);
    burst("R6", 12, 1'b1, 1'b0, 1'b1, 3'd0);
    burst("R6", 12, 1'b1, 1'b1, 1'b1, 3'd0);
    burst("R7", 6, 1'b1, 1'b1, 1'b1, 3'd1);
    burst("R7", 6, 1'b1, 1'b0, 1'b1, 3'd2);
    burst("R8", 9, 1'b0, 1'b1, 1'b0, 3'd3);
    burst("R9", 9, 1'b1, 1'b1, 1'b1, 3'd4);
    step("R10", 12'hABC, 1'b0, 1'b1, 1'b1, 1'b1, 3'd2, 1'b0);
    step("R10", 12'h555, 1'b1, 1'b1, 1'b1, 1'b1, 3'd1, 1'b0);
    burst("R10", 6, 1'b1, 1'b0, 1'b0, 3'd5);
    burst("R10", 6, 1'b0, 1'b1, 1'b0, 3'd6);
    burst("R10", 6, 1'b1, 1'b1, 1'b1, 3'd7);
    step("R11", 12'h3C3, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);
    step("R11", 12'h0F0, 1'b0, 1'b1, 1'b0, 1'b0, 3'd4, 1'b1);
    step("R11", 12'h111, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);
    step("R11", 12'h222, 1'b1, 1'b0, 1'b0, 1'b0, 3'd0, 1'b1);
    step("R11", 12'h333, 1'b0, 1'b0, 1'b0, 1'b0, 3'd0, 1'b0);

    rst_n = 1'b0;
    @(negedge clk);
    check("R1", out_word, 13'h0000);
    check("R1", {12'd0, out_oe}, 13'h0000);
    rst_n = 1'b1;
    edge_n = 0;
    step("R8", 12'h777, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0);
    step("R9", 12'h777, 1'b0, 1'b0, 1'b0, 1'b0, 3'd4, 1'b0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule